// File: doc/BRIEF.md
# Programmable Modulus Counter with Selectable Clear Style

This block is a binary up-counter that divides its clock by a modulus `p` given on an input port. The counter runs 0, 1, …, p-1 and then returns to 0, so one full pass takes exactly `p` clock periods. A terminal-count flag marks the last state of each pass and can serve as the divided clock.

The return to zero can be built in one of two ways, chosen by the `CLEAR_STYLE` parameter. In the synchronous style the counter compares its value with p-1 and loads zero on the next rising edge. In the asynchronous style the counter steps on to `p`. That value is decoded at once and clears the counter flops through their asynchronous clear. A level latch holds the clear until the clock goes low, so the clear pulse is wide enough for every flop to respond, and the value `p` lasts only for a transient. For a given decode value the two styles give different moduli: decoding 10 yields modulus 10 with the asynchronous clear and 11 with the synchronous one. For this reason each style compares against its own value, p-1 or p.

Top module: `modp_counter`

## Requirements
- R1: While `rst_n` is low the count is 0 and `term_cnt` is 0.
- R2: On each rising clock edge the count advances by exactly one, except on the edge that ends a pass.
- R3: In the synchronous style (`CLEAR_STYLE` = `CLR_SYNC`), a count of p-1 is followed on the next rising edge by a count of 0.
- R4: In the asynchronous style (`CLEAR_STYLE` = `CLR_ASYNC`), the count reaches `p` only as a transient and is forced to 0 in the same clock-high phase. The clear stays asserted until the clock goes low, so just after that rising edge the count already reads 0, and at no falling edge is it `p` or above.
- R5: `term_cnt` is 1 exactly while the count equals p-1, so it gives one single-cycle pulse every `p` clocks.
- R6: A `modulus` value of 0 or 1 acts as a modulus of 2.
- R7: In both styles the counted period equals `p` for any `p` from 2 up to 2^WIDTH-1, including the largest value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| modulus | input | WIDTH | Division ratio p |
| count | output | WIDTH | Current count value |
| term_cnt | output | 1 | High during the last state of each pass |

## Verification
The assertions assume that `modulus` stays constant while the counter runs out of reset. If it changed to a value below the current count, the count would run past the decode point and wrap through all of its codes. The stimulus therefore changes `modulus` only while `rst_n` is held low and releases reset afterwards. It samples the count both just after each rising edge and at each falling edge, which lets it observe the asynchronous clear after the transient and while the latch still holds the clear.

// File: rtl/modp_pkg.sv
package modp_pkg;
    typedef enum logic {
        CLR_SYNC  = 1'b0,
        CLR_ASYNC = 1'b1
    } clear_style_e;
endpackage

// File: rtl/modp_decode.sv
module modp_decode
    import modp_pkg::*;
#(
    parameter int           WIDTH       = 8,
    parameter clear_style_e CLEAR_STYLE = CLR_SYNC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] cnt,
    input  logic [WIDTH-1:0] modulus,
    output logic             wrap_sync,
    output logic             clr_async,
    output logic             term
);
    localparam logic [WIDTH-1:0] MIN_MOD = WIDTH'(2);

    logic [WIDTH-1:0] mod_eff;
    logic [WIDTH-1:0] last_val;

    always_comb begin
        mod_eff  = (modulus < MIN_MOD) ? MIN_MOD : modulus;
        last_val = mod_eff - WIDTH'(1);
        term     = (cnt == last_val);
    end

    generate
        if (CLEAR_STYLE == CLR_SYNC) begin : g_sync
            assign wrap_sync = (cnt == last_val);
            assign clr_async = 1'b0;
        end else begin : g_async
            logic hit;
            logic hold_q;
            assign hit = (cnt == mod_eff);
            // stretch the clear over the rest of the high phase
            always_latch begin
                if (!rst_n || !clk) hold_q = 1'b0;
                else if (hit)       hold_q = 1'b1;
            end
            assign wrap_sync = 1'b0;
            assign clr_async = hold_q | hit;
        end
    endgenerate
endmodule

// File: rtl/modp_core.sv
module modp_core #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_async,
    input  logic             wrap_sync,
    output logic [WIDTH-1:0] cnt
);
    typedef struct packed {
        logic [WIDTH-1:0] cnt;
    } core_state_t;

    core_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (wrap_sync) state_d.cnt = '0;
        else           state_d.cnt = state_q.cnt + WIDTH'(1);
    end

    always_ff @(posedge clk or negedge rst_n or posedge clr_async) begin
        if (!rst_n)         state_q <= '0;
        else if (clr_async) state_q <= '0;
        else                state_q <= state_d;
    end

    assign cnt = state_q.cnt;
endmodule

// File: rtl/modp_counter.sv
module modp_counter
    import modp_pkg::*;
#(
    parameter int           WIDTH       = 8,
    parameter clear_style_e CLEAR_STYLE = CLR_SYNC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] modulus,
    output logic [WIDTH-1:0] count,
    output logic             term_cnt
);
    logic             wrap_sync;
    logic             clr_async;
    logic             term;
    logic [WIDTH-1:0] cnt;

    modp_decode #(.WIDTH(WIDTH), .CLEAR_STYLE(CLEAR_STYLE)) u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt       (cnt),
        .modulus   (modulus),
        .wrap_sync (wrap_sync),
        .clr_async (clr_async),
        .term      (term)
    );

    modp_core #(.WIDTH(WIDTH)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_async (clr_async),
        .wrap_sync (wrap_sync),
        .cnt       (cnt)
    );

    assign count    = cnt;
    assign term_cnt = term;

    logic [WIDTH-1:0] chk_mod;
    assign chk_mod = (modulus < WIDTH'(2)) ? WIDTH'(2) : modulus;

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (count != chk_mod - WIDTH'(1)) |=> (count == $past(count) + WIDTH'(1))); // R2
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (count == chk_mod - WIDTH'(1)) |=> (count == '0)); // R3
    AST_BELOW_MOD: assert property (@(negedge clk) disable iff (!rst_n)
        (count < chk_mod)); // R4
    AST_TC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        term_cnt |=> !term_cnt); // R5
    AST_RESET_ZERO: assert property (@(posedge clk)
        !rst_n |-> (count == '0 && !term_cnt)); // R1
endmodule

// File: tb/modp_counter_tb.sv
module modp_counter_tb;
    import modp_pkg::*;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] modulus = '0;
    logic [W-1:0] cnt_s, cnt_a;
    logic         tc_s, tc_a;
    int           n_chk = 0;
    int           n_bad = 0;

    always #4 clk = ~clk;

    modp_counter #(.WIDTH(W), .CLEAR_STYLE(CLR_SYNC)) u_dut (
        .clk(clk), .rst_n(rst_n), .modulus(modulus), .count(cnt_s), .term_cnt(tc_s));
    modp_counter #(.WIDTH(W), .CLEAR_STYLE(CLR_ASYNC)) u_dut_async (
        .clk(clk), .rst_n(rst_n), .modulus(modulus), .count(cnt_a), .term_cnt(tc_a));

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // reset with a given modulus, then count over several passes
    task automatic run_period(input int p_in, input int passes, input string req);
        int p = (p_in < 2) ? 2 : p_in;
        int tcs_s = 0;
        int tcs_a = 0;
        @(negedge clk); #1;
        rst_n = 1'b0;
        modulus = W'(p_in);
        @(negedge clk); #1;
        check("R1 sync count", int'(cnt_s), 0);
        check("R1 async count", int'(cnt_a), 0);
        check("R1 sync tc", int'(tc_s), 0);
        check("R1 async tc", int'(tc_a), 0);
        rst_n = 1'b1;
        for (int k = 0; k < p * passes; k++) begin
            check({req, " R2 sync count"}, int'(cnt_s), k % p);
            check({req, " R4 async count"}, int'(cnt_a), k % p);
            check({req, " R5 sync tc"}, int'(tc_s), int'((k % p) == p - 1));
            check({req, " R5 async tc"}, int'(tc_a), int'((k % p) == p - 1));
            tcs_s += int'(tc_s);
            tcs_a += int'(tc_a);
            @(posedge clk); #1;
            check({req, " R3 sync after edge"}, int'(cnt_s), (k + 1) % p);
            check({req, " R4 async held clear"}, int'(cnt_a), (k + 1) % p);
            @(negedge clk); #1;
        end
        check({req, " R7 sync pulses"}, tcs_s, passes);
        check({req, " R7 async pulses"}, tcs_a, passes);
    endtask

    task automatic test_small_modulus();
        run_period(0, 4, "R6 mod0");
        run_period(1, 4, "R6 mod1");
        run_period(2, 4, "R6 mod2");
    endtask

    task automatic test_typical();
        run_period(10, 5, "R2 p10");
        run_period(27, 3, "R3 p27");
        run_period(51, 3, "R4 p51");
        run_period(3, 6, "R5 p3");
    endtask

    task automatic test_max();
        run_period((1 << W) - 1, 2, "R7 pmax");
    endtask

    initial begin
        fork
            begin
                test_small_modulus();
                test_typical();
                test_max();
            end
            begin
                repeat (100000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule